// File: doc/BRIEF.md
# Overvoltage Protection Latch Controller

This block watches a stream of digitized output-voltage samples from a multi-phase buck regulator and decides when the regulator must clamp its output. Each accepted sample is compared against a trip level. After soft-start, that level is the DAC setpoint plus a mode-dependent offset. During soft-start, the level never drops below a fixed floor. When a sample rises above the level, every low-side switch command is forced on and the fault flag, which pulls power-good low, is raised. The trip level in force at that moment is captured, and the clamp is released only when the output has fallen a fixed hysteresis below the captured level.

A released clamp normally leaves the controller latched off. The fault flag stays up and the block reports the latched condition, which the surrounding sequencer uses to inhibit any restart. The block keeps clamping whenever the output again exceeds the captured level. The one exception is soft-start: the first trip that starts during soft-start is forgiven on release, and any later trip latches. Deasserting enable or asserting power-on reset clears everything.

Top module: `ovp_latch_ctrl`

## Requirements
- R1: Outside soft-start, an accepted sample trips when it is strictly greater than the setpoint plus 175 mV (mode = 0) or plus 225 mV (mode = 1). A sample equal to that level does not trip.
- R2: During soft-start, the trip level is the larger of 1260 mV and the setpoint plus the mode offset.
- R3: On a trip, every bit of lgate_force and ov_fault go high at the clock edge that accepts the tripping sample.
- R4: The clamp releases at the edge accepting a sample less than or equal to the captured trip level minus 100 mV. Moving the setpoint while clamped does not change the release point.
- R5: Releasing a trip that is not forgiven sets latched_off and keeps ov_fault high until a clear.
- R6: While latched off, a sample above the captured trip level forces lgate_force high again. The next release returns lgate_force low with latched_off still high.
- R7: The first trip that begins during soft-start is forgiven. On its release, lgate_force and ov_fault return low and latched_off stays low. A second trip, whether during or after soft-start, latches on release.
- R8: While enable is low or por is high, all outputs go low at the next edge, and the latch and the forgiveness history are cleared.
- R9: Samples are taken only in cycles with sample_vld high. Outputs do not change on other cycles, whatever vout_mv does.
- R10: After the synchronous reset rst, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_vld | input | 1 | Strobe: vout_mv holds a new sample this cycle |
| vout_mv | input | 12 | Output voltage sample, mV |
| dac_mv | input | 12 | Regulation setpoint, mV |
| soft_start | input | 1 | High while the setpoint is ramping at start-up |
| mode | input | 1 | Offset select: 0 gives 175 mV, 1 gives 225 mV |
| enable | input | 1 | Controller enable; low clears the block |
| por | input | 1 | Power-on reset indication; high clears the block |
| lgate_force | output | 2 | Per-phase low-side force-on command |
| ov_fault | output | 1 | Overvoltage fault; power-good must be low while set |
| latched_off | output | 1 | Controller latched off; inhibits soft-start restart |

## Verification
The main comparison is driven with samples just below, exactly at, and one millivolt above each trip level. This separates strict from non-strict comparison and the two mode offsets. Soft-start samples are placed between the offset level and the 1260 mV floor, which shows whether the floor is applied and applied only then. Release samples are placed at the captured level minus 100 mV and one millivolt above it, after the setpoint has been moved, which shows whether hysteresis follows the captured level or the live setpoint. Trip and release sequences with one and two trips in soft-start, one trip straddling its end, and a recurrence while latched distinguish the forgiven path from the latching path.

// File: rtl/ovp_pkg.sv
package ovp_pkg;

  // Sequencer states of the protection controller
  typedef enum logic [1:0] {
    ST_WATCH = 2'd0,  // monitoring, switches free
    ST_CLAMP = 2'd1,  // low-side switches forced on
    ST_LOCK  = 2'd2   // overvoltage gone, controller held off
  } ovp_state_e;

endpackage

// File: rtl/ovp_trip_level.sv
module ovp_trip_level #(
  parameter int VW       = 12,
  parameter int FLOOR_MV = 1260,
  parameter int OFS_A_MV = 175,
  parameter int OFS_B_MV = 225
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode,
  input  logic          soft_start,
  input  logic [VW-1:0] dac_mv,
  output logic [VW:0]   level_mv
);

  localparam int LW = VW + 1;
  localparam logic [LW-1:0] FLOOR = LW'(FLOOR_MV);
  localparam logic [LW-1:0] OFS_A = LW'(OFS_A_MV);
  localparam logic [LW-1:0] OFS_B = LW'(OFS_B_MV);

  logic [LW-1:0] offset;
  logic [LW-1:0] base_lvl;

  assign offset   = mode ? OFS_B : OFS_A;
  assign base_lvl = {1'b0, dac_mv} + offset;

  always_comb begin
    level_mv = base_lvl;
    if (soft_start && (base_lvl < FLOOR)) level_mv = FLOOR;
  end

  // R2
  ss_floor_chk: assert property (@(posedge clk) disable iff (rst)
    soft_start |-> (level_mv >= FLOOR));

endmodule

// File: rtl/ovp_window.sv
module ovp_window #(
  parameter int VW      = 12,
  parameter int HYST_MV = 100
) (
  input  logic [VW-1:0] vout_mv,
  input  logic [VW:0]   level_mv,
  input  logic [VW:0]   held_mv,
  output logic          above_level,
  output logic          above_held,
  output logic          at_release
);

  localparam int LW = VW + 2;
  localparam logic [LW-1:0] HYST = LW'(HYST_MV);

  logic [LW-1:0] v_ext;

  assign v_ext       = {2'b00, vout_mv};
  assign above_level = v_ext > {1'b0, level_mv};
  assign above_held  = v_ext > {1'b0, held_mv};
  // Sample at or below held - hysteresis; written with the addition on the
  // sample side, so no underflow occurs
  assign at_release  = (v_ext + HYST) <= {1'b0, held_mv};

endmodule

// File: rtl/ovp_seq.sv
module ovp_seq
  import ovp_pkg::*;
#(
  parameter int VW  = 12,
  parameter int NPH = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           sample_vld,
  input  logic           soft_start,
  input  logic           enable,
  input  logic           por,
  input  logic [VW:0]    level_mv,
  input  logic           above_level,
  input  logic           above_held,
  input  logic           at_release,
  output logic [VW:0]    held_mv,
  output logic [NPH-1:0] lgate_force,
  output logic           ov_fault,
  output logic           latched_off
);

  ovp_state_e state_q;
  logic       forgive_q;
  logic       ss_used_q;
  logic       fault_q;
  logic       latch_q;
  logic       clear;

  assign clear = !enable || por;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      state_q   <= ST_WATCH;
      held_mv   <= '0;
      forgive_q <= 1'b0;
      ss_used_q <= 1'b0;
      fault_q   <= 1'b0;
      latch_q   <= 1'b0;
    end else if (sample_vld) begin
      case (state_q)
        ST_WATCH: begin
          if (above_level) begin
            state_q   <= ST_CLAMP;
            held_mv   <= level_mv;
            forgive_q <= soft_start && !ss_used_q;
            fault_q   <= 1'b1;
          end
        end
        ST_CLAMP: begin
          if (at_release) begin
            if (forgive_q) begin
              state_q   <= ST_WATCH;
              ss_used_q <= 1'b1;
              forgive_q <= 1'b0;
              fault_q   <= 1'b0;
            end else begin
              state_q <= ST_LOCK;
              latch_q <= 1'b1;
            end
          end
        end
        ST_LOCK: begin
          if (above_held) begin
            state_q   <= ST_CLAMP;
            forgive_q <= 1'b0;
          end
        end
        default: state_q <= ST_WATCH;
      endcase
    end
  end

  // One force flop per phase so each driver input has its own register
  for (genvar p = 0; p < NPH; p++) begin : g_phase
    logic force_q;
    always_ff @(posedge clk) begin
      if (rst || clear) force_q <= 1'b0;
      else if (sample_vld) begin
        case (state_q)
          ST_WATCH: force_q <= above_level;
          ST_CLAMP: force_q <= !at_release;
          ST_LOCK:  force_q <= above_held;
          default:  force_q <= 1'b0;
        endcase
      end
    end
    assign lgate_force[p] = force_q;
  end

  assign ov_fault    = fault_q;
  assign latched_off = latch_q;

  // R3
  force_flags_fault_chk: assert property (@(posedge clk) disable iff (rst)
    lgate_force[0] |-> ov_fault);

  // R8
  clear_drops_all_chk: assert property (@(posedge clk) disable iff (rst)
    clear |=> (lgate_force == '0) && !ov_fault && !latched_off);

  // R9
  idle_cycle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!sample_vld && !clear) |=> $stable(lgate_force) && $stable(latched_off)
                                 && $stable(ov_fault));

  // R5
  latch_sticks_chk: assert property (@(posedge clk) disable iff (rst)
    (latched_off && !clear) |=> latched_off && ov_fault);

  // R6
  all_phases_agree_chk: assert property (@(posedge clk) disable iff (rst)
    (lgate_force == '0) || (lgate_force == '1));

endmodule

// File: rtl/ovp_latch_ctrl.sv
module ovp_latch_ctrl #(
  parameter int VW       = 12,
  parameter int NPH      = 2,
  parameter int FLOOR_MV = 1260,
  parameter int OFS_A_MV = 175,
  parameter int OFS_B_MV = 225,
  parameter int HYST_MV  = 100
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           sample_vld,
  input  logic [VW-1:0]  vout_mv,
  input  logic [VW-1:0]  dac_mv,
  input  logic           soft_start,
  input  logic           mode,
  input  logic           enable,
  input  logic           por,
  output logic [NPH-1:0] lgate_force,
  output logic           ov_fault,
  output logic           latched_off
);

  logic [VW:0] level_mv;
  logic [VW:0] held_mv;
  logic        above_level;
  logic        above_held;
  logic        at_release;

  ovp_trip_level #(
    .VW(VW), .FLOOR_MV(FLOOR_MV), .OFS_A_MV(OFS_A_MV), .OFS_B_MV(OFS_B_MV)
  ) u_level (
    .clk(clk), .rst(rst), .mode(mode), .soft_start(soft_start),
    .dac_mv(dac_mv), .level_mv(level_mv)
  );

  ovp_window #(.VW(VW), .HYST_MV(HYST_MV)) u_win (
    .vout_mv(vout_mv), .level_mv(level_mv), .held_mv(held_mv),
    .above_level(above_level), .above_held(above_held), .at_release(at_release)
  );

  ovp_seq #(.VW(VW), .NPH(NPH)) u_seq (
    .clk(clk), .rst(rst), .sample_vld(sample_vld), .soft_start(soft_start),
    .enable(enable), .por(por), .level_mv(level_mv),
    .above_level(above_level), .above_held(above_held), .at_release(at_release),
    .held_mv(held_mv), .lgate_force(lgate_force), .ov_fault(ov_fault),
    .latched_off(latched_off)
  );

endmodule

// File: tb/ovp_latch_ctrl_test.sv
module ovp_latch_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int VW = 12;
  localparam int NPH = 2;
  localparam int NVEC = 24;

  // entry: en, por, ss, mode, dac[11:0], vout[11:0], exp force, exp fault, exp latched
  localparam logic [30:0] VEC [0:NVEC-1] = '{
    {4'b1000, 12'd1000, 12'd1100, 3'b000}, // R1 below 1175
    {4'b1000, 12'd1000, 12'd1175, 3'b000}, // R1 equal, no trip
    {4'b1000, 12'd1000, 12'd1176, 3'b110}, // R1 R3 trip
    {4'b1000, 12'd1000, 12'd1100, 3'b110}, // R4 above release
    {4'b1000, 12'd900,  12'd1076, 3'b110}, // R4 setpoint moved, 1 mV short
    {4'b1000, 12'd900,  12'd1075, 3'b011}, // R4 R5 release -> latch
    {4'b1000, 12'd900,  12'd1000, 3'b011}, // R5 holds
    {4'b1000, 12'd900,  12'd1180, 3'b111}, // R6 recurrence
    {4'b1000, 12'd900,  12'd1000, 3'b011}, // R6 release again
    {4'b0000, 12'd900,  12'd1000, 3'b000}, // R8 enable low
    {4'b1011, 12'd1000, 12'd1230, 3'b000}, // R2 floor 1260 in mode B
    {4'b1011, 12'd1000, 12'd1261, 3'b110}, // R2 trip above floor
    {4'b1011, 12'd1000, 12'd1160, 3'b000}, // R7 forgiven release
    {4'b1011, 12'd1000, 12'd1261, 3'b110}, // R7 second trip
    {4'b1011, 12'd1000, 12'd1160, 3'b011}, // R7 second release latches
    {4'b1111, 12'd1000, 12'd1000, 3'b000}, // R8 por
    {4'b1011, 12'd1100, 12'd1325, 3'b000}, // R2 offset above floor, equal
    {4'b1011, 12'd1100, 12'd1326, 3'b110}, // R2 trip at 1325
    {4'b1001, 12'd1100, 12'd1225, 3'b000}, // R7 forgiven after ss ends
    {4'b1001, 12'd1100, 12'd1326, 3'b110}, // R1 mode B normal trip
    {4'b1001, 12'd1100, 12'd1225, 3'b011}, // R5 latches
    {4'b0000, 12'd1100, 12'd1225, 3'b000}, // R8 clear
    {4'b1010, 12'd1000, 12'd1260, 3'b000}, // R2 mode A floor, equal
    {4'b1010, 12'd1000, 12'd1261, 3'b110}  // R2 mode A floor trip
  };

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           sample_vld = 1'b0;
  logic [VW-1:0]  vout_mv = '0;
  logic [VW-1:0]  dac_mv = '0;
  logic           soft_start = 1'b0;
  logic           mode = 1'b0;
  logic           enable = 1'b0;
  logic           por = 1'b0;
  logic [NPH-1:0] lgate_force;
  logic           ov_fault;
  logic           latched_off;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ovp_latch_ctrl uut (
    .clk(clk), .rst(rst), .sample_vld(sample_vld), .vout_mv(vout_mv),
    .dac_mv(dac_mv), .soft_start(soft_start), .mode(mode), .enable(enable),
    .por(por), .lgate_force(lgate_force), .ov_fault(ov_fault),
    .latched_off(latched_off)
  );

  task automatic check(input string req, input logic ef, input logic eo, input logic el);
    logic [NPH-1:0] fexp;
    fexp = ef ? '1 : '0;
    n_chk++;
    if (lgate_force !== fexp || ov_fault !== eo || latched_off !== el) begin
      n_bad++;
      $display("FAIL %s: force=%b fault=%b latched=%b expected force=%b fault=%b latched=%b",
               req, lgate_force, ov_fault, latched_off, fexp, eo, el);
    end
  endtask

  // Called at a negedge: drive, let one posedge pass, return at next negedge
  task automatic drive(input logic en, input logic p, input logic ss, input logic md,
                       input logic [VW-1:0] dac, input logic [VW-1:0] v, input logic vld);
    enable = en; por = p; soft_start = ss; mode = md;
    dac_mv = dac; vout_mv = v; sample_vld = vld;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10", 1'b0, 1'b0, 1'b0);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      logic [30:0] e;
      e = VEC[i];
      drive(e[30], e[29], e[28], e[27], e[26:15], e[14:3], 1'b1);
      check($sformatf("R1-table[%0d] R2 R3 R4 R5 R6 R7 R8", i), e[2], e[1], e[0]);
    end

    // R9: no strobe, high sample ignored
    drive(1'b0, 1'b0, 1'b0, 1'b0, 12'd1000, 12'd1000, 1'b1);
    drive(1'b1, 1'b0, 1'b0, 1'b0, 12'd1000, 12'd1500, 1'b0);
    drive(1'b1, 1'b0, 1'b0, 1'b0, 12'd1000, 12'd1500, 1'b0);
    check("R9 no strobe no trip", 1'b0, 1'b0, 1'b0);
    drive(1'b1, 1'b0, 1'b0, 1'b0, 12'd1000, 12'd1500, 1'b1);
    check("R9 strobe trips", 1'b1, 1'b1, 1'b0);
    drive(1'b1, 1'b0, 1'b0, 1'b0, 12'd1000, 12'd500, 1'b0);
    check("R9 no strobe no release", 1'b1, 1'b1, 1'b0);
    drive(1'b1, 1'b0, 1'b0, 1'b0, 12'd1000, 12'd500, 1'b1);
    check("R5 release latches", 1'b0, 1'b1, 1'b1);
    // R8: held enable low keeps outputs low even with high samples
    drive(1'b0, 1'b0, 1'b0, 1'b0, 12'd1000, 12'd1500, 1'b1);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 12'd1000, 12'd1500, 1'b1);
    check("R8 disabled ignores samples", 1'b0, 1'b0, 1'b0);
    // R10: reset in the middle of a clamp
    drive(1'b1, 1'b0, 1'b0, 1'b1, 12'd1000, 12'd1226, 1'b1);
    check("R1 mode B 1226 trips", 1'b1, 1'b1, 1'b0);
    rst = 1'b1;
    drive(1'b1, 1'b0, 1'b0, 1'b1, 12'd1000, 12'd1226, 1'b0);
    check("R10 reset clears clamp", 1'b0, 1'b0, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule